// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block loads a bitstream into a target FPGA over its slave-serial configuration pins. A start pulse makes it assert the chip-select, drive the active-low program line low for a fixed number of cycles, release it, and wait a clear delay while the target erases its configuration memory. At the end of that delay the target's DONE line must be low. If it is still high, the load stops at once with a clear failure.

Once the target has cleared, payload bytes are accepted one at a time through a valid/ready handshake. Each byte is shifted out most significant bit first. Every bit has four equal slots: data set up with the configuration clock low, two slots with the clock high, then one slot with the clock low. The byte flagged as last starts a post-load delay. DONE is then sampled: high means success, low means the target is stuck busy.

All delays count system clock cycles and are parameters, so a host clock of any rate can meet the target's timing. The three status flags hold their value until the next accepted start.

Top module: `sscfg_loader`

## Requirements
- R1: While reset is held, and in the cycle after it is released, prog_n_o is 1 and cs_o, cclk_o, din_o, ready_o, busy_o, ok_o, fail_clear_o and fail_stuck_o are all 0.
- R2: A start_i pulse seen while idle sets busy_o and cs_o in the next cycle. prog_n_o is then 0 for exactly PROG_CYC cycles, and cs_o stays 1 for as long as prog_n_o is 0.
- R3: If done_i is low in the last cycle of the clear delay, ready_o first rises exactly CLEAR_CYC cycles after prog_n_o returns to 1.
- R4: If done_i is high in the last cycle of the clear delay, fail_clear_o rises and busy_o and cs_o fall exactly CLEAR_CYC cycles after prog_n_o returns to 1. No cclk_o pulse is produced and ready_o never rises.
- R5: Each byte leaves on din_o most significant bit first. din_o holds its value for as long as cclk_o is high, so the target sees each bit on a rising edge of cclk_o.
- R6: Each bit lasts 4*SLOT_CYC cycles: SLOT_CYC low with the data in place, 2*SLOT_CYC high, and SLOT_CYC low. Every byte gives exactly eight rising edges of cclk_o.
- R7: ready_o is high only while no byte is being shifted, and never while cclk_o is high. A byte is taken in a cycle where valid_i and ready_o are both 1. While no byte is offered, cclk_o stays low.
- R8: After the byte marked by last_i, the status appears and busy_o falls SLOT_CYC+POST_CYC cycles after the final falling edge of cclk_o. If done_i is high at that point, ok_o is set.
- R9: If done_i is low at the end of the post-load delay, fail_stuck_o is set instead of ok_o.
- R10: At most one status flag is set at a time. The flags hold their value until the next start_i accepted while idle, which clears them. A start_i while busy has no effect: no second program pulse and no break in the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a configuration (used only when idle) |
| data_i | input | DW | Payload byte |
| valid_i | input | 1 | data_i holds a byte |
| last_i | input | 1 | Byte on data_i is the final one |
| ready_o | output | 1 | Loader can accept a byte |
| done_i | input | 1 | DONE line from the target |
| prog_n_o | output | 1 | Active-low program line to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data to the target |
| cs_o | output | 1 | Chip-select, active during a configuration |
| busy_o | output | 1 | Configuration in progress |
| ok_o | output | 1 | Last configuration succeeded |
| fail_clear_o | output | 1 | Target did not acknowledge the memory clear |
| fail_stuck_o | output | 1 | DONE stayed low after the load |

## Verification
A wrong sequencer state shows at the pins within one cycle. A program pulse that is one cycle too long, a ready that opens a cycle early or late, or a status set in the wrong cycle changes a measured distance between edges, and those distances are checked against the parameter arithmetic. A fault in the shifter's slot or bit counters shows within one bit period (4*SLOT_CYC cycles) as a high phase of the wrong length, a wrong spacing between rising edges, or a captured byte that differs. Sweeping all 256 byte values exposes any bit-order or bit-drop fault. The three DONE scenarios separate the two failure paths from the success path.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_CLEAR = 3'd2,
    ST_FETCH = 3'd3,
    ST_SHIFT = 3'd4,
    ST_POST  = 3'd5
  } cfg_state_e;

  // Slot order within one bit; the order is the wire protocol.
  typedef enum logic [1:0] {
    SL_SETUP = 2'd0,
    SL_HI_A  = 2'd1,
    SL_HI_B  = 2'd2,
    SL_FALL  = 2'd3
  } slot_e;

  localparam int unsigned SLOTS_PER_BIT = 4;

endpackage

// File: rtl/sscfg_timer.sv
module sscfg_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] init,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  // A load of N keeps the owning state alive for exactly N cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= init - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TMR_NONZERO_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |-> (init != '0)); // R3

endmodule

// File: rtl/sscfg_shifter.sv
module sscfg_shifter
  import sscfg_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned SLOT_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] byte_i,
  output logic          cclk_o,
  output logic          din_o,
  output logic          active_o,
  output logic          last_tick_o
);

  localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;
  localparam int unsigned SW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(SLOT_CYC - 1);
  localparam logic [BW-1:0] BIT_TOP  = BW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [BW-1:0] bit_q;
  slot_e         slot_q;
  logic [SW-1:0] sub_q;
  logic          act_q;
  logic          cclk_q;
  logic          din_q;
  logic          sub_end;

  assign sub_end     = (sub_q == SUB_LAST);
  assign last_tick_o = act_q && sub_end && (slot_q == SL_FALL) && (bit_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      bit_q  <= '0;
      slot_q <= SL_SETUP;
      sub_q  <= '0;
      act_q  <= 1'b0;
      cclk_q <= 1'b0;
      din_q  <= 1'b0;
    end else if (load) begin
      sh_q   <= byte_i;
      bit_q  <= BIT_TOP;
      slot_q <= SL_SETUP;
      sub_q  <= '0;
      act_q  <= 1'b1;
      cclk_q <= 1'b0;
      din_q  <= byte_i[DW-1];
    end else if (act_q) begin
      if (!sub_end) begin
        sub_q <= sub_q + 1'b1;
      end else begin
        sub_q <= '0;
        unique case (slot_q)
          SL_SETUP: begin
            slot_q <= SL_HI_A;
            cclk_q <= 1'b1;
          end
          SL_HI_A: begin
            slot_q <= SL_HI_B;
          end
          SL_HI_B: begin
            slot_q <= SL_FALL;
            cclk_q <= 1'b0;
          end
          SL_FALL: begin
            slot_q <= SL_SETUP;
            if (bit_q == '0) begin
              act_q <= 1'b0;
              din_q <= 1'b0;
            end else begin
              bit_q <= bit_q - 1'b1;
              sh_q  <= {sh_q[DW-2:0], 1'b0};
              din_q <= sh_q[DW-2];
            end
          end
          default: slot_q <= SL_SETUP;
        endcase
      end
    end
  end

  assign cclk_o   = cclk_q;
  assign din_o    = din_q;
  assign active_o = act_q;

  AST_CCLK_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_q) |=> cclk_q); // R6
  AST_DIN_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cclk_q && $past(cclk_q)) |-> $stable(din_q)); // R5
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !act_q); // R7
  AST_CCLK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    cclk_q |-> act_q); // R7

endmodule

// File: rtl/sscfg_ctrl.sv
module sscfg_ctrl
  import sscfg_pkg::*;
#(
  parameter int unsigned TW        = 8,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned CLEAR_CYC = 16,
  parameter int unsigned POST_CYC  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic          last_i,
  input  logic          done_i,
  input  logic          t_zero,
  input  logic          byte_end,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output logic          s_load,
  output logic          ready_o,
  output logic          prog_n_o,
  output logic          cs_o,
  output logic          busy_o,
  output logic          ok_o,
  output logic          fail_clear_o,
  output logic          fail_stuck_o
);

  localparam logic [TW-1:0] V_PROG  = TW'(PROG_CYC);
  localparam logic [TW-1:0] V_CLEAR = TW'(CLEAR_CYC);
  localparam logic [TW-1:0] V_POST  = TW'(POST_CYC);

  cfg_state_e st_q, nxt;
  logic       last_q;
  logic       ready_q, prog_n_q, cs_q, busy_q;
  logic       ok_q, fc_q, fs_q;
  logic       go, set_ok, set_fc, set_fs;

  assign go = (st_q == ST_IDLE) && start_i;

  always_comb begin
    nxt    = st_q;
    t_load = 1'b0;
    t_val  = '0;
    s_load = 1'b0;
    set_ok = 1'b0;
    set_fc = 1'b0;
    set_fs = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          nxt    = ST_PROG;
          t_load = 1'b1;
          t_val  = V_PROG;
        end
      end
      ST_PROG: begin
        if (t_zero) begin
          nxt    = ST_CLEAR;
          t_load = 1'b1;
          t_val  = V_CLEAR;
        end
      end
      ST_CLEAR: begin
        if (t_zero) begin
          if (done_i) begin
            nxt    = ST_IDLE;
            set_fc = 1'b1;
          end else begin
            nxt = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (valid_i && ready_q) begin
          nxt    = ST_SHIFT;
          s_load = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (byte_end) begin
          if (last_q) begin
            nxt    = ST_POST;
            t_load = 1'b1;
            t_val  = V_POST;
          end else begin
            nxt = ST_FETCH;
          end
        end
      end
      ST_POST: begin
        if (t_zero) begin
          nxt = ST_IDLE;
          if (done_i) set_ok = 1'b1;
          else        set_fs = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      last_q   <= 1'b0;
      ready_q  <= 1'b0;
      prog_n_q <= 1'b1;
      cs_q     <= 1'b0;
      busy_q   <= 1'b0;
      ok_q     <= 1'b0;
      fc_q     <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      st_q     <= nxt;
      ready_q  <= (nxt == ST_FETCH);
      prog_n_q <= (nxt != ST_PROG);
      cs_q     <= (nxt != ST_IDLE);
      busy_q   <= (nxt != ST_IDLE);
      if (s_load) last_q <= last_i;
      if (go) begin
        ok_q <= 1'b0;
        fc_q <= 1'b0;
        fs_q <= 1'b0;
      end else begin
        if (set_ok) ok_q <= 1'b1;
        if (set_fc) fc_q <= 1'b1;
        if (set_fs) fs_q <= 1'b1;
      end
    end
  end

  assign ready_o      = ready_q;
  assign prog_n_o     = prog_n_q;
  assign cs_o         = cs_q;
  assign busy_o       = busy_q;
  assign ok_o         = ok_q;
  assign fail_clear_o = fc_q;
  assign fail_stuck_o = fs_q;

  AST_PROG_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    !prog_n_q |-> cs_q); // R2
  AST_CLEAR_FAIL_ENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(fc_q) |-> (!busy_q && !cs_q)); // R4
  AST_READY_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (busy_q && prog_n_q)); // R7
  AST_OK_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> !busy_q); // R8
  AST_STUCK_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_q) |-> !busy_q); // R9
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok_q, fc_q, fs_q})); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && prog_n_q && start_i) |=> prog_n_q); // R10

endmodule

// File: rtl/sscfg_loader.sv
module sscfg_loader
  import sscfg_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned SLOT_CYC  = 4,
  parameter int unsigned PROG_CYC  = 100,
  parameter int unsigned CLEAR_CYC = 5_000_000,
  parameter int unsigned POST_CYC  = 10_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  input  logic          last_i,
  output logic          ready_o,
  input  logic          done_i,
  output logic          prog_n_o,
  output logic          cclk_o,
  output logic          din_o,
  output logic          cs_o,
  output logic          busy_o,
  output logic          ok_o,
  output logic          fail_clear_o,
  output logic          fail_stuck_o
);

  localparam int unsigned MAX_AB = (PROG_CYC > CLEAR_CYC) ? PROG_CYC : CLEAR_CYC;
  localparam int unsigned MAX_D  = (MAX_AB > POST_CYC) ? MAX_AB : POST_CYC;
  localparam int unsigned TW     = $clog2(MAX_D + 1);

  logic          t_load, t_zero, s_load, s_active, s_last;
  logic [TW-1:0] t_val;

  sscfg_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .init    (t_val),
    .expired (t_zero)
  );

  sscfg_shifter #(.DW(DW), .SLOT_CYC(SLOT_CYC)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .load        (s_load),
    .byte_i      (data_i),
    .cclk_o      (cclk_o),
    .din_o       (din_o),
    .active_o    (s_active),
    .last_tick_o (s_last)
  );

  sscfg_ctrl #(
    .TW        (TW),
    .PROG_CYC  (PROG_CYC),
    .CLEAR_CYC (CLEAR_CYC),
    .POST_CYC  (POST_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .valid_i      (valid_i),
    .last_i       (last_i),
    .done_i       (done_i),
    .t_zero       (t_zero),
    .byte_end     (s_last),
    .t_load       (t_load),
    .t_val        (t_val),
    .s_load       (s_load),
    .ready_o      (ready_o),
    .prog_n_o     (prog_n_o),
    .cs_o         (cs_o),
    .busy_o       (busy_o),
    .ok_o         (ok_o),
    .fail_clear_o (fail_clear_o),
    .fail_stuck_o (fail_stuck_o)
  );

  AST_READY_CCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!cclk_o && !s_active)); // R7
  AST_CCLK_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    cclk_o |-> (cs_o && prog_n_o)); // R6

endmodule

// File: tb/sscfg_loader_test.sv
module sscfg_loader_test;

  localparam int S  = 2;
  localparam int P  = 3;
  localparam int CL = 6;
  localparam int PO = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       start_i = 1'b0;
  logic [7:0] data_i  = '0;
  logic       valid_i = 1'b0;
  logic       last_i  = 1'b0;
  logic       done_i  = 1'b1;
  logic ready_o, prog_n_o, cclk_o, din_o, cs_o, busy_o, ok_o, fail_clear_o, fail_stuck_o;

  sscfg_loader #(.DW(8), .SLOT_CYC(S), .PROG_CYC(P), .CLEAR_CYC(CL), .POST_CYC(PO)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i), .valid_i(valid_i),
    .last_i(last_i), .ready_o(ready_o), .done_i(done_i), .prog_n_o(prog_n_o),
    .cclk_o(cclk_o), .din_o(din_o), .cs_o(cs_o), .busy_o(busy_o), .ok_o(ok_o),
    .fail_clear_o(fail_clear_o), .fail_stuck_o(fail_stuck_o)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Target model and port monitor, all at the falling edge.
  int mode = 0;            // 0 normal, 1 never clears, 2 never completes
  int exp_total = 0;
  int cyc = 0, rises = 0, bits_since = 0, hi_run = 0, last_rise = 0, bit_in_byte = 0;
  int bad_hi = 0, bad_per = 0, bad_bit = 0, bad_din = 0, rx_bytes = 0, overlap = 0;
  int prog_pulses = 0, prog_w = 0, last_prog_w = 0, t_prog_rise = 0, t_ready = 0;
  int need_ready = 0, t_last_fall = 0, t_busy_fall = 0, ready_cnt = 0;
  logic [7:0] rx = '0;
  logic [7:0] exp_q [0:511];
  int push_idx = 0;
  logic prev_cclk = 1'b0, prev_prog = 1'b1, prev_busy = 1'b0, prev_din = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!prog_n_o) begin
        prog_w++;
        bits_since = 0;
        done_i = (mode == 1);
      end
      if (prog_n_o && !prev_prog) begin
        prog_pulses++;
        last_prog_w = prog_w;
        prog_w = 0;
        t_prog_rise = cyc;
        need_ready = 1;
      end
      if (ready_o) ready_cnt++;
      if (ready_o && need_ready != 0) begin
        t_ready = cyc;
        need_ready = 0;
      end
      if (ready_o && cclk_o) overlap++;
      if (cclk_o && prev_cclk && din_o !== prev_din) bad_din++;
      if (cclk_o) hi_run++;
      if (cclk_o && !prev_cclk) begin
        rises++;
        bits_since++;
        if (bit_in_byte != 0 && cyc - last_rise != 4 * S) bad_per++;
        last_rise = cyc;
        rx = {rx[6:0], din_o};
        bit_in_byte++;
        if (bit_in_byte == 8) begin
          if (rx !== exp_q[rx_bytes]) bad_bit++;
          rx_bytes++;
          bit_in_byte = 0;
        end
        if (mode == 0 && bits_since == exp_total) done_i = 1'b1;
      end
      if (!cclk_o && prev_cclk) begin
        if (hi_run != 2 * S) bad_hi++;
        hi_run = 0;
        t_last_fall = cyc;
      end
      if (!busy_o && prev_busy) t_busy_fall = cyc;
    end
    prev_cclk = cclk_o;
    prev_prog = prog_n_o;
    prev_busy = busy_o;
    prev_din  = din_o;
  end

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic lst, input int gap);
    repeat (gap) @(negedge clk);
    data_i  = b;
    last_i  = lst;
    valid_i = 1'b1;
    exp_q[push_idx] = b;
    push_idx++;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    last_i  = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int r0, b0, rc0, pp0, stall_hi;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk("R1 prog_n in reset", prog_n_o, 1);
    chk("R1 idle outputs in reset",
        {cs_o, cclk_o, din_o, ready_o, busy_o, ok_o, fail_clear_o, fail_stuck_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 prog_n after reset", prog_n_o, 1);
    chk("R1 idle outputs after reset",
        {cs_o, cclk_o, din_o, ready_o, busy_o, ok_o, fail_clear_o, fail_stuck_o}, 0);

    // Run A: all 256 byte values, success path
    mode = 0;
    exp_total = 256 * 8;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy,cs,prog_n after start", {busy_o, cs_o, prog_n_o}, 3'b110);
    stall_hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (i == 50) pulse_start();   // R10: ignored while busy
      if (i == 100) begin
        while (!ready_o) @(negedge clk);
        for (int k = 0; k < 30; k++) begin
          @(negedge clk);
          if (cclk_o) stall_hi++;
        end
      end
      send(i[7:0], (i == 255), i % 3);
    end
    wait_idle();
    chk("R7 cclk low while stream stalls", stall_hi, 0);
    chk("R2 program pulse width", last_prog_w, P);
    chk("R3 clear delay to first ready", t_ready - t_prog_rise, CL);
    chk("R10 single program pulse despite start while busy", prog_pulses, 1);
    chk("R6 rising edges for 256 bytes", rises, 2048);
    chk("R6 high phase length errors", bad_hi, 0);
    chk("R6 bit period errors", bad_per, 0);
    chk("R5 bytes received", rx_bytes, 256);
    chk("R5 MSB-first byte mismatches", bad_bit, 0);
    chk("R5 din changes while cclk high", bad_din, 0);
    chk("R7 ready while cclk high", overlap, 0);
    chk("R8 post delay from last cclk fall", t_busy_fall - t_last_fall, S + PO);
    chk("R8 status ok/clear/stuck", {ok_o, fail_clear_o, fail_stuck_o}, 3'b100);
    chk("R8 cs released", cs_o, 0);
    repeat (40) @(negedge clk);
    chk("R10 status held while idle", {ok_o, fail_clear_o, fail_stuck_o}, 3'b100);

    // Run B: target never clears
    mode = 1;
    r0 = rises;
    rc0 = ready_cnt;
    pp0 = prog_pulses;
    pulse_start();
    chk("R10 start clears status", {ok_o, fail_clear_o, fail_stuck_o}, 0);
    wait_idle();
    chk("R4 status ok/clear/stuck", {ok_o, fail_clear_o, fail_stuck_o}, 3'b010);
    chk("R4 abort timing after program release", t_busy_fall - t_prog_rise, CL);
    chk("R4 no cclk pulses", rises - r0, 0);
    chk("R4 ready never raised", ready_cnt - rc0, 0);
    chk("R2 one program pulse for run B", prog_pulses - pp0, 1);
    chk("R4 cs released", cs_o, 0);

    // Run C: target never reports done after load
    mode = 2;
    exp_total = 24;
    b0 = rx_bytes;
    pulse_start();
    send(8'hA5, 1'b0, 0);
    send(8'h3C, 1'b0, 5);
    send(8'h81, 1'b1, 0);
    wait_idle();
    chk("R9 status ok/clear/stuck", {ok_o, fail_clear_o, fail_stuck_o}, 3'b001);
    chk("R5 run C bytes", rx_bytes - b0, 3);
    chk("R5 run C mismatches", bad_bit, 0);
    chk("R8 run C post delay", t_busy_fall - t_last_fall, S + PO);

    summary();
    $finish;
  end

endmodule